// File: doc/BRIEF.md
# Fuzzy Error-Driven Correction Controller

This block turns a stream of sampled, signed error values into a signed control correction by fuzzy inference. Each accepted sample is paired with the previous accepted sample to form a change in error. Both quantities are scaled by a fixed gain and clamped to a unit range. Each is then graded against seven triangular sets, numbered 0 (negative big) to 6 (positive big).

A constant 7x7 rule table, derived at elaboration from a weighted law u = -(alpha·E + (1-alpha)·CE), picks an output set for every pair of input sets. Each rule fires with the smaller of its two grades. The correction is the strength-weighted average of the chosen output peaks, found by a bit-serial divider.

A one-cycle `in_valid` strobe starts a computation. A one-cycle `out_valid` pulse presents the result, which then stays on `u_out` until the next result. All values are Q1.14 (16384 = 1.0).

Top module: `fuzzy_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` goes to 0, `u_out` goes to 0 and the stored previous error is cleared, so the first sample after reset uses a change in error equal to the error itself.
- R2: The change in error is the accepted `err_in` minus the previously accepted `err_in`, formed in 17 bits without wrap.
- R3: Each input is scaled as floor(x·GAIN/256), with GAIN = 256 by default, then saturated to the range [-16384, +16384].
- R4: For a scaled value x, let p = 3·(x + 16384). Set j (0..6) has degree max(0, 16384 - |p - 16384·j|). At most two adjacent sets are non-zero, and their degrees add to 16384.
- R5: For error set e and change set c, let s = A·(e-3) + (256-A)·(c-3), with A = ALPHA = 128 by default. The rule's output set is 3 - round(s/256), rounded half away from zero. Output set k has peak trunc((k-3)·16384/3).
- R6: A rule fires with the minimum of its two input degrees. Rules of zero strength add nothing.
- R7: `u_out` is the sum of strength·peak divided by the sum of strengths, truncated toward zero.
- R8: `out_valid` is high for exactly one cycle. It is sampled high after the 17th rising edge that follows the edge that accepted `in_valid`, well inside a 40-cycle budget.
- R9: An `in_valid` strobe that arrives while a computation is in flight is ignored. It produces no extra result and does not change the stored previous error.
- R10: Between result pulses, `u_out` holds its value, and changes of `err_in` without `in_valid` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: accept `err_in` this cycle when idle |
| err_in | input | 16 | Signed Q1.14 error sample |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| u_out | output | 16 | Signed Q1.14 control correction |

## Verification
The embedded properties take for granted that reset is applied before the first strobe. The divider's bound on its first partial remainder rests on every output peak lying within ±1.0, so it holds for any `err_in` code. The stimulus therefore uses the full input range, including -2.0 and values that force saturation, and it places strobes inside a busy window. Expected corrections come from a separate model that grades every one of the 49 rules by distance rather than by segment index.

// File: rtl/fuzzy_pkg.sv
package fuzzy_pkg;
  localparam int NSET = 7;
  localparam int MID  = (NSET - 1) / 2;
  localparam int SETW = $clog2(NSET);

  typedef logic [SETW-1:0] set_idx_t;

  // Output set chosen by the weighted law for one pair of input sets.
  function automatic int rule_out(int e_idx, int c_idx, int alpha, int afrac);
    int full, s, r, o;
    full = 1 << afrac;
    s = alpha * (e_idx - MID) + (full - alpha) * (c_idx - MID);
    if (s >= 0) r = (s + full / 2) / full;
    else        r = -((full / 2 - s) / full);
    o = MID - r;
    if (o < 0) o = 0;
    if (o > NSET - 1) o = NSET - 1;
    return o;
  endfunction

  // Singleton peak of output set k, truncated toward zero.
  function automatic int set_peak(int k, int one);
    return ((k - MID) * one) / MID;
  endfunction
endpackage

// File: rtl/fuzzy_fuzzify.sv
module fuzzy_fuzzify
  import fuzzy_pkg::*;
#(
  parameter int XW    = 17,
  parameter int FRAC  = 14,
  parameter int GAIN  = 256,
  parameter int GFRAC = 8
) (
  input  logic signed [XW-1:0] x,
  output set_idx_t             idx_lo,
  output set_idx_t             idx_hi,
  output logic [FRAC:0]        mu_lo,
  output logic [FRAC:0]        mu_hi
);
  localparam int ONE  = 1 << FRAC;
  localparam int PW   = XW + 32;
  localparam int POSW = FRAC + SETW;
  localparam logic signed [FRAC+1:0] XS_MAX = (FRAC+2)'(ONE);
  localparam logic signed [FRAC+1:0] XS_MIN = -XS_MAX;

  logic signed [PW-1:0]   prod, shifted;
  logic signed [FRAC+1:0] xs;
  logic [POSW-1:0]        pos;
  logic [SETW-1:0]        seg;
  logic [FRAC-1:0]        frac;
  int                     pos_i;

  // Gain and clamp to the unit range.
  always_comb begin
    prod    = PW'(x) * PW'(GAIN);
    shifted = prod >>> GFRAC;
    if (shifted > PW'(ONE))       xs = XS_MAX;
    else if (shifted < -PW'(ONE)) xs = XS_MIN;
    else                          xs = shifted[FRAC+1:0];
  end

  // Position on the set axis: one set per ONE of distance.
  always_comb begin
    pos_i = (int'(xs) + ONE) * MID;
    pos   = POSW'(pos_i);
    seg   = pos[POSW-1:FRAC];
    frac  = pos[FRAC-1:0];
  end

  always_comb begin
    idx_lo = seg;
    if (seg >= SETW'(NSET - 1)) idx_hi = SETW'(NSET - 1);
    else                        idx_hi = seg + 1'b1;
    mu_hi = {1'b0, frac};
    mu_lo = (FRAC+1)'(ONE) - {1'b0, frac};
  end
endmodule

// File: rtl/fuzzy_rules.sv
module fuzzy_rules
  import fuzzy_pkg::*;
#(
  parameter int FRAC  = 14,
  parameter int W     = 16,
  parameter int ALPHA = 128,
  parameter int AFRAC = 8,
  parameter int NUMW  = FRAC + W + 3,
  parameter int DENW  = FRAC + 3
) (
  input  set_idx_t                 e_lo,
  input  set_idx_t                 e_hi,
  input  set_idx_t                 c_lo,
  input  set_idx_t                 c_hi,
  input  logic [FRAC:0]            me_lo,
  input  logic [FRAC:0]            me_hi,
  input  logic [FRAC:0]            mc_lo,
  input  logic [FRAC:0]            mc_hi,
  output logic signed [NUMW-1:0]   num,
  output logic [DENW-1:0]          den
);
  localparam int ONE   = 1 << FRAC;
  localparam int MW    = FRAC + 1;
  localparam int NFIRE = 4;

  typedef logic [NSET-1:0][NSET-1:0][SETW-1:0] rtab_t;
  typedef logic [NSET-1:0][W-1:0]              ptab_t;

  function automatic rtab_t build_rules();
    rtab_t t;
    for (int e = 0; e < NSET; e++)
      for (int c = 0; c < NSET; c++)
        t[e][c] = SETW'(rule_out(e, c, ALPHA, AFRAC));
    return t;
  endfunction

  function automatic ptab_t build_peaks();
    ptab_t t;
    for (int k = 0; k < NSET; k++) t[k] = W'(set_peak(k, ONE));
    return t;
  endfunction

  localparam rtab_t RULES = build_rules();
  localparam ptab_t PEAKS = build_peaks();

  logic [MW-1:0]          str  [NFIRE];
  logic signed [NUMW-1:0] term [NFIRE];

  // The four candidate rules: {low,high} error set x {low,high} change set.
  for (genvar g = 0; g < NFIRE; g++) begin : g_fire
    localparam int SE = g / 2;
    localparam int SC = g % 2;
    set_idx_t      ie, ic, oset;
    logic [MW-1:0] me, mc;
    assign ie     = (SE != 0) ? e_hi  : e_lo;
    assign ic     = (SC != 0) ? c_hi  : c_lo;
    assign me     = (SE != 0) ? me_hi : me_lo;
    assign mc     = (SC != 0) ? mc_hi : mc_lo;
    assign oset   = RULES[ie][ic];
    assign str[g] = (me < mc) ? me : mc;
    assign term[g] = NUMW'($signed({1'b0, str[g]})) * NUMW'($signed(PEAKS[oset]));
  end

  always_comb begin
    num = '0;
    den = '0;
    for (int i = 0; i < NFIRE; i++) begin
      num = num + term[i];
      den = den + DENW'(str[i]);
    end
  end
endmodule

// File: rtl/fuzzy_divider.sv
module fuzzy_divider #(
  parameter int NUMW = 33,
  parameter int DENW = 17,
  parameter int QB   = 15
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic signed [NUMW-1:0] num,
  input  logic [DENW-1:0]        den,
  output logic                   done,
  output logic signed [QB:0]     quo
);
  localparam int CW = $clog2(QB + 1);

  logic [NUMW-1:0] mag;
  logic [DENW-1:0] rem, dv;
  logic [QB-1:0]   qr;
  logic            neg, run, take;
  logic [CW-1:0]   cnt;
  logic [DENW:0]   trial;

  assign mag   = num[NUMW-1] ? -num : num;
  assign trial = {rem, qr[QB-1]};
  assign take  = trial >= {1'b0, dv};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      dv   <= '0;
      qr   <= '0;
      neg  <= 1'b0;
      run  <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        // High quotient bits are known zero: the average is within one peak.
        rem <= DENW'(mag >> QB);
        qr  <= mag[QB-1:0];
        dv  <= den;
        neg <= num[NUMW-1];
        cnt <= CW'(QB);
        run <= 1'b1;
      end else if (run) begin
        rem <= take ? DENW'(trial - {1'b0, dv}) : trial[DENW-1:0];
        qr  <= {qr[QB-2:0], take};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = neg ? -$signed({1'b0, qr}) : $signed({1'b0, qr});

  AST_DIV_PRECOND: assert property (@(posedge clk) disable iff (rst)
    start |-> (mag >> QB) < NUMW'(den)); // R7
  AST_REM_BELOW: assert property (@(posedge clk) disable iff (rst)
    run |-> rem < dv); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    start |-> !run); // R9
endmodule

// File: rtl/fuzzy_ctrl.sv
module fuzzy_ctrl
  import fuzzy_pkg::*;
#(
  parameter int W          = 16,
  parameter int FRAC       = 14,
  parameter int E_GAIN     = 256,
  parameter int C_GAIN     = 256,
  parameter int GAIN_FRAC  = 8,
  parameter int ALPHA      = 128,
  parameter int ALPHA_FRAC = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] err_in,
  output logic                out_valid,
  output logic signed [W-1:0] u_out
);
  localparam int ONE  = 1 << FRAC;
  localparam int DW   = W + 1;
  localparam int MW   = FRAC + 1;
  localparam int NUMW = MW + W + 2;
  localparam int DENW = MW + 2;
  localparam int QB   = W - 1;
  localparam int LAT  = QB + 2;
  localparam int LCW  = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_DIV} state_t;

  state_t               st;
  logic signed [W-1:0]  err_q, prev_err;
  logic signed [DW-1:0] derr_q;
  logic                 accept, div_start, div_done;
  logic signed [QB:0]   div_quo;
  logic signed [NUMW-1:0] num;
  logic [DENW-1:0]      den;
  set_idx_t             e_lo, e_hi, c_lo, c_hi;
  logic [MW-1:0]        me_lo, me_hi, mc_lo, mc_hi;
  logic [LCW-1:0]       lat_cnt;
  logic                 armed;

  assign accept    = (st == ST_IDLE) && in_valid;
  assign div_start = (st == ST_CALC);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      err_q     <= '0;
      derr_q    <= '0;
      prev_err  <= '0;
      out_valid <= 1'b0;
      u_out     <= '0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        ST_IDLE: if (in_valid) begin
          err_q    <= err_in;
          derr_q   <= DW'(err_in) - DW'(prev_err);
          prev_err <= err_in;
          st       <= ST_CALC;
        end
        ST_CALC: st <= ST_DIV;
        ST_DIV: if (div_done) begin
          u_out     <= div_quo;
          out_valid <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  fuzzy_fuzzify #(.XW(DW), .FRAC(FRAC), .GAIN(E_GAIN), .GFRAC(GAIN_FRAC)) i_fz_err (
    .x(DW'(err_q)), .idx_lo(e_lo), .idx_hi(e_hi), .mu_lo(me_lo), .mu_hi(me_hi));

  fuzzy_fuzzify #(.XW(DW), .FRAC(FRAC), .GAIN(C_GAIN), .GFRAC(GAIN_FRAC)) i_fz_chg (
    .x(derr_q), .idx_lo(c_lo), .idx_hi(c_hi), .mu_lo(mc_lo), .mu_hi(mc_hi));

  fuzzy_rules #(.FRAC(FRAC), .W(W), .ALPHA(ALPHA), .AFRAC(ALPHA_FRAC),
                .NUMW(NUMW), .DENW(DENW)) i_rules (
    .e_lo(e_lo), .e_hi(e_hi), .c_lo(c_lo), .c_hi(c_hi),
    .me_lo(me_lo), .me_hi(me_hi), .mc_lo(mc_lo), .mc_hi(mc_hi),
    .num(num), .den(den));

  fuzzy_divider #(.NUMW(NUMW), .DENW(DENW), .QB(QB)) i_div (
    .clk(clk), .rst(rst), .start(div_start), .num(num), .den(den),
    .done(div_done), .quo(div_quo));

  // Observation state for the properties below.
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cnt <= '0;
      armed   <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (accept)              lat_cnt <= '0;
      else if (st != ST_IDLE)  lat_cnt <= lat_cnt + 1'b1;
    end
  end

  AST_ACCEPT_PREV: assert property (@(posedge clk) disable iff (rst)
    accept |=> prev_err == $past(err_in)); // R2
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> $stable(prev_err)); // R9
  AST_MEMB_SUM: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CALC) |-> ((MW+1)'(me_lo) + (MW+1)'(me_hi) == (MW+1)'(ONE)) &&
                        ((MW+1)'(mc_lo) + (MW+1)'(mc_hi) == (MW+1)'(ONE))); // R4
  AST_DEN_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CALC) |-> den >= DENW'(ONE / 2)); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R8
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> lat_cnt == LCW'(LAT)); // R8
  AST_LAT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> lat_cnt < LCW'(40)); // R8
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    (armed && !out_valid) |-> $stable(u_out)); // R10
endmodule

// File: tb/test_fuzzy_ctrl.sv
module test_fuzzy_ctrl;
  localparam longint ONE = 16384;
  localparam int     NV  = 8;
  localparam int     EXP_LAT = 17;

  // Table: error sample and hand-derived correction, applied right after reset.
  localparam logic signed [15:0] TV_ERR [NV] = '{16'sd0, 16'sd16384, 16'sd16384,
    16'sd8192, 16'sd24576, -16'sd32768, 16'sd4096, 16'sd2048};
  localparam logic signed [15:0] TV_U   [NV] = '{16'sd0, -16'sd16384, -16'sd10922,
    16'sd0, -16'sd16384, 16'sd16384, -16'sd10922, 16'sd0};
  localparam int NS = 8;
  localparam logic signed [15:0] SW_ERR [NS] = '{16'sd300, -16'sd7000, 16'sd12345,
    -16'sd12000, 16'sd5000, 16'sd16000, -16'sd1, 16'sd9999};

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [15:0] err_in = '0;
  logic out_valid;
  logic signed [15:0] u_out;
  int checks = 0, errors = 0;
  longint m_prev = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fuzzy_ctrl i_fuzzy_ctrl (.clk(clk), .rst(rst), .in_valid(in_valid), .err_in(err_in),
    .out_valid(out_valid), .u_out(u_out));

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint clamp1(longint v);
    if (v > ONE) return ONE;
    if (v < -ONE) return -ONE;
    return v;
  endfunction

  // Independent model: grade all 49 rules by distance on the set axis.
  function automatic longint model(longint e, longint p);
    longint xe, xc, num, den, d, w, s, r, k, pk;
    longint me [7];
    longint mc [7];
    xe = clamp1((e * 256) >>> 8);
    xc = clamp1(((e - p) * 256) >>> 8);
    for (int j = 0; j < 7; j++) begin
      d = 3 * (xe + ONE) - j * ONE; if (d < 0) d = -d;
      me[j] = (d < ONE) ? ONE - d : 0;
      d = 3 * (xc + ONE) - j * ONE; if (d < 0) d = -d;
      mc[j] = (d < ONE) ? ONE - d : 0;
    end
    num = 0; den = 0;
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++) begin
        w = (me[a] < mc[b]) ? me[a] : mc[b];
        s = 128 * (a - 3) + 128 * (b - 3);
        r = (s >= 0) ? (s + 128) / 256 : -((128 - s) / 256);
        k = 3 - r;
        pk = ((k - 3) * ONE) / 3;
        num += w * pk;
        den += w;
      end
    return num / den;
  endfunction

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    m_prev = 0;
  endtask

  task automatic run_sample(input logic signed [15:0] e, output longint got, output int lat);
    err_in = e; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; lat = 0;
    while (!out_valid && lat < 60) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    got = u_out;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint got, hold, exp1;
    int lat, pulses;
    @(negedge clk);
    do_reset();
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 u_out after reset", u_out, 0);

    // Table walk: R2 R3 R5 R7 with hand-derived results; R8 latency each time.
    for (int i = 0; i < NV; i++) begin
      run_sample(TV_ERR[i], got, lat);
      check($sformatf("R5/R7 table %0d", i), got, TV_U[i]);
      check($sformatf("R8 latency %0d", i), lat, EXP_LAT);
      @(posedge clk); @(negedge clk);
      check($sformatf("R8 pulse width %0d", i), out_valid, 0);
      m_prev = TV_ERR[i];
    end

    // Sweep with fractional averages: R2 R3 R4 R6 R7.
    for (int i = 0; i < NS; i++) begin
      exp1 = model(SW_ERR[i], m_prev);
      run_sample(SW_ERR[i], got, lat);
      check($sformatf("R4/R6/R7 sweep %0d", i), got, exp1);
      m_prev = SW_ERR[i];
    end

    // R10: output holds, err_in changes without strobe have no effect.
    hold = u_out; pulses = 0;
    for (int n = 0; n < 12; n++) begin
      err_in = 16'(n * 3001 - 15000);
      @(posedge clk); @(negedge clk);
      if (out_valid || u_out != hold) pulses++;
    end
    check("R10 hold without strobe", pulses, 0);
    exp1 = model(-16'sd3000, m_prev);
    run_sample(-16'sd3000, got, lat);
    check("R10/R2 unstrobed inputs not stored", got, exp1);
    m_prev = -3000;

    // R9: strobe during a computation is ignored.
    exp1 = model(7000, m_prev);
    err_in = 16'sd7000; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; pulses = 0; got = 0;
    for (int n = 1; n <= 40; n++) begin
      if (n == 5) begin err_in = -16'sd14000; in_valid = 1'b1; end
      if (n == 6) in_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      if (out_valid) begin pulses++; got = u_out; end
    end
    check("R9 single result", pulses, 1);
    check("R9 result of first sample", got, exp1);
    m_prev = 7000;
    exp1 = model(-2500, m_prev);
    run_sample(-16'sd2500, got, lat);
    check("R9 previous error unchanged", got, exp1);

    // R1: reset clears the previous error.
    run_sample(16'sd9000, got, lat);
    do_reset();
    check("R1 out_valid after second reset", out_valid, 0);
    check("R1 u_out after second reset", u_out, 0);
    exp1 = model(-5000, 0);
    run_sample(-16'sd5000, got, lat);
    check("R1 previous error cleared", got, exp1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule